// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block gathers single-cycle event pulses from a contactless reader datapath (timer expiry, transmit done, receive done, idle, FIFO high alert and FIFO low alert) into a sticky request register. An enable register of the same layout masks each request. The OR of all unmasked requests forms a combined interrupt flag. That flag also drives an external interrupt pin, and a small configuration register sets the pin's polarity and drive style.

Software never overwrites the request or enable register as a whole. Each write carries an action bit. The action either sets or clears the positions marked 1 in the low six bits, and every other bit keeps its value. This lets independent software threads acknowledge or arm single sources without a read-modify-write. The register interface is plain control and status: one write strobe with a select, and one read select with a combinational read port. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `irq_sc_ctrl`

## Requirements
- R1: After reset the request and enable registers read 00h, the configuration register reads 02h, the flag is 0, and the pin is driven (oe=1) with value 0.
- R2: A write to a set/clear register (select 0 = enable, 1 = request) with bit 7 = 1 sets each bit marked 1 in bits 5..0 and leaves all other bits unchanged.
- R3: A write to a set/clear register with bit 7 = 0 clears each bit marked 1 in bits 5..0 and leaves all other bits unchanged. Without a write or an event, the register holds its value.
- R4: An event pulse on source i sets request bit i at the next clock edge. The bit stays set until a clear write removes it. Source positions are 5 timer, 4 transmit, 3 receive, 2 idle, 1 FIFO high, 0 FIFO low.
- R5: When an event and a clear write hit the same request bit in the same cycle, the bit ends up set.
- R6: The flag is 1 exactly when some request bit and its matching enable bit are both 1.
- R7: Reading select 0 or 1 returns bit 7 = 0, bit 6 = 0 and the register's bits 5..0. A 1 written to bit 6 has no effect. Select 3 reads 00h.
- R8: Configuration (select 2) is overwritten by a plain write of bits 1..0. Bit 0 = 1 inverts the pin level relative to the flag.
- R9: With configuration bit 1 = 1 (push-pull), oe=1 and the pin value is the level. With bit 1 = 0 (open drain), the pin value is 0 and oe is 1 only when the level is 0.
- R10: A write to one select leaves the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | Event pulses, one per source |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 enable, 1 request, 2 config |
| wr_data | input | 8 | Write data; bit 7 is the set/clear action |
| rd_sel | input | 2 | Read target, same encoding, 3 reads zero |
| rd_data | output | 8 | Read data (combinational) |
| irq_flag | output | 1 | Combined masked interrupt status |
| irq_pin_o | output | 1 | Pin data value |
| irq_pin_oe | output | 1 | Pin output enable |

## Verification
Every register change, whether it comes from a write or an event, shows one clock edge after the stimulus. The flag, the pin and the read data follow that state combinationally in the same cycle, and the read data also follows rd_sel in the same cycle. The bench drives inputs just after the falling edge. At each falling edge it compares all outputs against a behavioural model updated on the rising edge. The directed checks then read a register back, or sample the pin, one full cycle after each write.

// File: rtl/irq_sc_pkg.sv
package irq_sc_pkg;
  localparam int NUM_SRC = 6;
  localparam int DATA_W  = 8;
  localparam int CFG_W   = 2;
  localparam int SEL_W   = 2;
  localparam int ACT_BIT = DATA_W - 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_EN  = 2'd0,
    SEL_REQ = 2'd1,
    SEL_CFG = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam logic [CFG_W-1:0] CFG_RESET = 2'b10;
endpackage

// File: rtl/irq_sc_reg.sv
module irq_sc_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic         wr_set,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[i] <= 1'b0;
      end else if (evt[i]) begin
        q[i] <= 1'b1;
      end else if (wr_hit && wr_mask[i]) begin
        q[i] <= wr_set;
      end
    end
  end
endmodule

// File: rtl/irq_pin_stage.sv
module irq_pin_stage (
  input  logic flag,
  input  logic invert,
  input  logic push_pull,
  output logic pin_o,
  output logic pin_oe
);
  logic level;
  assign level = flag ^ invert;

  always_comb begin
    if (push_pull) begin
      pin_o  = level;
      pin_oe = 1'b1;
    end else begin
      pin_o  = 1'b0;
      pin_oe = ~level;
    end
  end
endmodule

// File: rtl/irq_sc_ctrl.sv
module irq_sc_ctrl
  import irq_sc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  evt_i,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  output logic                irq_flag,
  output logic                irq_pin_o,
  output logic                irq_pin_oe
);
  localparam int PAD_SC  = DATA_W - NUM_SRC;
  localparam int PAD_CFG = DATA_W - CFG_W;

  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] en_q;
  logic [CFG_W-1:0]   cfg_q;
  logic               hit_en, hit_req;
  logic               unused_bits;

  assign hit_en  = wr_en && (wr_sel == SEL_EN);
  assign hit_req = wr_en && (wr_sel == SEL_REQ);
  assign unused_bits = &{1'b0, wr_data[DATA_W-2:NUM_SRC]};

  irq_sc_reg #(.W(NUM_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_en), .wr_set(wr_data[ACT_BIT]),
    .wr_mask(wr_data[NUM_SRC-1:0]), .evt('0), .q(en_q)
  );

  irq_sc_reg #(.W(NUM_SRC)) u_req (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_req), .wr_set(wr_data[ACT_BIT]),
    .wr_mask(wr_data[NUM_SRC-1:0]), .evt(evt_i), .q(req_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (wr_en && (wr_sel == SEL_CFG)) begin
      cfg_q <= wr_data[CFG_W-1:0];
    end
  end

  assign irq_flag = |(req_q & en_q);

  irq_pin_stage u_pin (
    .flag(irq_flag), .invert(cfg_q[0]), .push_pull(cfg_q[1]),
    .pin_o(irq_pin_o), .pin_oe(irq_pin_oe)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_EN:  rd_data = {{PAD_SC{1'b0}}, en_q};
      SEL_REQ: rd_data = {{PAD_SC{1'b0}}, req_q};
      SEL_CFG: rd_data = {{PAD_CFG{1'b0}}, cfg_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_sc_chk.sv
module irq_sc_chk
  import irq_sc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               wr_en,
  input logic [SEL_W-1:0]   wr_sel,
  input logic [DATA_W-1:0]  wr_data,
  input logic [DATA_W-1:0]  rd_data,
  input logic [NUM_SRC-1:0] req_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [CFG_W-1:0]   cfg_q,
  input logic               irq_flag,
  input logic               irq_pin_o,
  input logic               irq_pin_oe
);
  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_EN && wr_data[ACT_BIT])
    |=> ((en_q & $past(wr_data[NUM_SRC-1:0])) == $past(wr_data[NUM_SRC-1:0])));

  assert_en_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_EN) |=> $stable(en_q));

  assert_req_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_sel == SEL_REQ) && evt_i == '0) |=> $stable(req_q));

  assert_event_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((req_q & $past(evt_i)) == $past(evt_i)));

  assert_no_spurious_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & en_q) == '0) |-> !irq_flag);

  assert_top_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1 -: 2] == 2'b00);

  assert_open_drain_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[1] |-> !irq_pin_o);

  assert_push_pull_drives_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[1] |-> irq_pin_oe);
endmodule

bind irq_sc_ctrl irq_sc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .rd_data(rd_data), .req_q(req_q), .en_q(en_q),
  .cfg_q(cfg_q), .irq_flag(irq_flag), .irq_pin_o(irq_pin_o),
  .irq_pin_oe(irq_pin_oe)
);

// File: tb/tb_irq_sc_ctrl.sv
`timescale 1ns/1ps
module tb_irq_sc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt_i = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       irq_flag, irq_pin_o, irq_pin_oe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  int m_en = 0, m_req = 0, m_cfg = 2;

  always #2.5 clk = ~clk;

  irq_sc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_flag(irq_flag),
    .irq_pin_o(irq_pin_o), .irq_pin_oe(irq_pin_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_req = 0; m_cfg = 2;
    end else begin
      int mask;
      mask = wr_data & 8'h3F;
      if (wr_en && wr_sel == 2'd0) m_en  = wr_data[7] ? (m_en | mask)  : (m_en & ~mask);
      if (wr_en && wr_sel == 2'd1) m_req = wr_data[7] ? (m_req | mask) : (m_req & ~mask);
      if (wr_en && wr_sel == 2'd2) m_cfg = wr_data & 3;
      m_req = m_req | evt_i;
    end
  end

  function automatic int exp_rd(input int sel);
    case (sel)
      0: return m_en;
      1: return m_req;
      2: return m_cfg;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int fl, lvl, eo, eoe;
      fl  = ((m_req & m_en) != 0) ? 1 : 0;
      lvl = fl ^ (m_cfg & 1);
      if (m_cfg & 2) begin eo = lvl; eoe = 1; end
      else begin eo = 0; eoe = (lvl == 0) ? 1 : 0; end
      check(irq_flag == fl, "R6 flag per cycle", irq_flag, fl);
      check({irq_pin_o, irq_pin_oe} == {eo[0], eoe[0]}, "R9 pin per cycle",
            {irq_pin_o, irq_pin_oe}, {eo[0], eoe[0]});
      check(rd_data == exp_rd(rd_sel), "R7 read per cycle", rd_data, exp_rd(rd_sel));
    end
  end

  task automatic wr(input int sel, input int data, input int ev = 0);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data[7:0]; evt_i = ev[5:0];
    @(negedge clk); #1;
    wr_en = 1'b0; wr_data = '0; evt_i = '0;
  endtask

  task automatic pulse(input int ev);
    @(negedge clk); #1;
    evt_i = ev[5:0];
    @(negedge clk); #1;
    evt_i = '0;
  endtask

  task automatic rd_chk(input int sel, input int exp, input string tag);
    rd_sel = sel[1:0];
    #1;
    check(rd_data == exp[7:0], tag, rd_data, exp);
  endtask

  task automatic pin_chk(input int exp_o, input int exp_oe, input string tag);
    check({irq_pin_o, irq_pin_oe} == {exp_o[0], exp_oe[0]}, tag,
          {irq_pin_o, irq_pin_oe}, {exp_o[0], exp_oe[0]});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    rd_chk(0, 8'h00, "R1 enable reset");
    rd_chk(1, 8'h00, "R1 request reset");
    rd_chk(2, 8'h02, "R1 config reset");
    check(irq_flag == 1'b0, "R1 flag reset", irq_flag, 0);
    pin_chk(0, 1, "R1 pin reset");

    // R2 / R3 set and clear on the enable register
    wr(0, 8'hAA);            rd_chk(0, 8'h2A, "R2 set marked bits");
    wr(0, 8'h81);            rd_chk(0, 8'h2B, "R2 others unchanged");
    wr(0, 8'h02);            rd_chk(0, 8'h29, "R3 clear marked bits");
    wr(0, 8'hFF);            rd_chk(0, 8'h3F, "R7 bit6 ignored, readback");
    rd_chk(1, 8'h00, "R10 request untouched by enable write");

    // R4 event latched and sticky
    pulse(6'h20);
    rd_chk(1, 8'h20, "R4 timer event latched");
    repeat (3) @(negedge clk);
    #1 rd_chk(1, 8'h20, "R4 request sticky");
    check(irq_flag == 1'b1, "R6 flag with enabled request", irq_flag, 1);
    wr(0, 8'h20);
    check(irq_flag == 1'b0, "R6 flag masked", irq_flag, 0);
    rd_chk(1, 8'h20, "R10 request kept after enable write");

    // R5 event beats clear
    pulse(6'h02);
    rd_chk(1, 8'h22, "R4 FIFO high latched");
    wr(1, 8'h02, 6'h02);     rd_chk(1, 8'h22, "R5 event wins over clear");
    wr(1, 8'h02);            rd_chk(1, 8'h20, "R3 clear request bit");
    rd_chk(0, 8'h1F, "R10 enable untouched by request write");

    // R8 / R9 pin configuration with flag = 1
    wr(0, 8'hA0);
    check(irq_flag == 1'b1, "R6 flag re-enabled", irq_flag, 1);
    pin_chk(1, 1, "R9 push-pull high");
    wr(2, 8'hFF);            rd_chk(2, 8'h03, "R8 config readback");
    pin_chk(0, 1, "R8 inverted push-pull");
    wr(2, 8'h00);            pin_chk(0, 0, "R9 open drain released");
    wr(2, 8'h01);            pin_chk(0, 1, "R9 open drain inverted pulls low");
    wr(1, 8'h3F);            rd_chk(1, 8'h00, "R3 clear all requests");
    check(irq_flag == 1'b0, "R6 flag idle", irq_flag, 0);
    pin_chk(0, 0, "R9 open drain inverted released");
    wr(2, 8'h00);            pin_chk(0, 1, "R9 open drain idle pulls low");

    // multiple sources pending
    pulse(6'h19);
    rd_chk(1, 8'h19, "R4 several sources pending");
    check(irq_flag == 1'b1, "R6 OR over sources", irq_flag, 1);
    rd_chk(3, 8'h00, "R7 unused select reads zero");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule